// File: doc/BRIEF.md
# Byte ALU with Chained-Compare Flags

This block is the 8-bit arithmetic and logic unit of a small processor datapath. Each accepted request carries two operands, an operation code and the present flag byte. One clock later the block returns the result, a new flag byte and a write enable that tells the register file whether to store the result. The operations are add, add with carry, subtract, subtract with carry, compare, compare with carry, increment, decrement, AND, OR, XOR, one's complement, negate, nibble swap, logical right shift, rotate right through carry and arithmetic right shift.

Two flag rules let software chain byte operations into wider ones. Increment and decrement leave the carry alone, so they can serve as loop counters in wide arithmetic. The with-carry subtract and compare can clear Z but never set it, so a run of compares reports equality only when every byte matched.

Operation codes on `op`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 increment, 7 decrement, 8 AND, 9 OR, 10 XOR, 11 complement, 12 negate, 13 swap, 14 logical right shift, 15 rotate right, 16 arithmetic right shift. Flag byte layout: bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H.

Top module: `byte_alu`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one cycle. `result`, `flags_out` and `write_en` show that request's outcome in that same cycle. `write_en` is low whenever `out_valid` is low. Reset clears all outputs to zero.
- R2: Add (op 0, 1) and subtract/compare (op 2 to 5) form a+b(+C) or a-b(-C). For these operations C (flag bit 0) is the carry out of bit 7 or the unsigned borrow, H (bit 5) is the carry out of bit 3 or the borrow into bit 4, and V (bit 3) is signed overflow. For every operation that updates flags, N (bit 2) is result bit 7, Z (bit 1) is set for a zero result, and S (bit 4) = N xor V.
- R3: Increment (op 6) and decrement (op 7) leave C and H at their incoming values. V is set only for 0x7F incremented or 0x80 decremented.
- R4: Subtract with carry (op 3) and compare with carry (op 5) produce Z = incoming Z AND (result == 0).
- R5: Compare operations (op 4, 5) update the flags but drive `write_en` low. Every other defined operation drives it high.
- R6: Add of a value to itself gives a left shift with bit 7 into C. Add with carry gives a left rotate through C.
- R7: Swap (op 13) exchanges bits 7:4 with bits 3:0 and leaves all six flags unchanged.
- R8: The right shifts (op 14, 15, 16) load operand bit 0 into C. Bit 7 of the result is 0 for op 14, the incoming C for op 15, and operand bit 7 for op 16. V = N xor C, and H is unchanged.
- R9: AND, OR and XOR (op 8, 9, 10) clear V and keep C and H. Complement (op 11) clears V, sets C and keeps H.
- R10: Negate (op 12) gives 0-a. C is set when a is nonzero, V is set only for a = 0x80, and H is set when a's low nibble is nonzero.
- R11: Codes 17 to 31 return `result` = a with the flags unchanged and `write_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Operation code |
| a | input | 8 | First operand (destination value) |
| b | input | 8 | Second operand |
| flags_in | input | 6 | Current flags {H,S,V,N,Z,C} |
| out_valid | output | 1 | Outcome present |
| result | output | 8 | Operation result |
| flags_out | output | 6 | New flags {H,S,V,N,Z,C} |
| write_en | output | 1 | Store result to destination |

## Verification
On every cycle, the assertions check the one-cycle handshake, the carry kept by increment and decrement, the rule that the chained subtract and compare never set Z, the write enable held low for compares, swap's result and frozen flags, and S = N xor V for all flag-updating operations. Exact sums, borrows, half-carries, overflow corners, the shift and rotate fills, negate's edge values and the handling of unused codes can be seen only in the bench's scenarios. The bench checks each of these against a reference model in its scoreboard.

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [5:0]   flags_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [5:0]   flags_out,
  output logic         write_en
);
  localparam int M  = W - 1;
  localparam int HB = W / 2 - 1;
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4,  OP_CPC = 5'd5,  OP_INC = 5'd6,  OP_DEC = 5'd7;
  localparam logic [4:0] OP_AND = 5'd8,  OP_OR  = 5'd9,  OP_XOR = 5'd10, OP_COM = 5'd11;
  localparam logic [4:0] OP_NEG = 5'd12, OP_SWP = 5'd13, OP_LSR = 5'd14, OP_ROR = 5'd15;
  localparam logic [4:0] OP_ASR = 5'd16;

  logic         cin;
  logic [W:0]   sum_w, dif_w;
  logic [W-1:0] sa, sb, r;
  logic         c, z, n, v, h, upd, chain, we;

  assign cin   = flags_in[0];
  assign sa    = (op == OP_NEG) ? '0 : a;
  assign sb    = (op == OP_NEG) ? a : b;
  assign sum_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (op == OP_ADC) & cin};
  assign dif_w = {1'b0, sa} - {1'b0, sb}
               - {{W{1'b0}}, ((op == OP_SBC) || (op == OP_CPC)) & cin};

  always_comb begin
    r     = a;
    c     = flags_in[0];
    z     = flags_in[1];
    n     = flags_in[2];
    v     = flags_in[3];
    h     = flags_in[5];
    upd   = 1'b1;
    chain = 1'b0;
    we    = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        r = sum_w[M:0];
        c = sum_w[W];
        h = (a[HB] & b[HB]) | (b[HB] & ~r[HB]) | (~r[HB] & a[HB]);
        v = (a[M] & b[M] & ~r[M]) | (~a[M] & ~b[M] & r[M]);
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
        r     = dif_w[M:0];
        c     = dif_w[W];
        h     = (~sa[HB] & sb[HB]) | (sb[HB] & r[HB]) | (r[HB] & ~sa[HB]);
        v     = (sa[M] & ~sb[M] & ~r[M]) | (~sa[M] & sb[M] & r[M]);
        chain = (op == OP_SBC) || (op == OP_CPC);
        we    = (op != OP_CMP) && (op != OP_CPC);
      end
      OP_INC: begin
        r = a + 1'b1;
        v = ~a[M] & r[M];
      end
      OP_DEC: begin
        r = a - 1'b1;
        v = a[M] & ~r[M];
      end
      OP_AND: begin r = a & b; v = 1'b0; end
      OP_OR:  begin r = a | b; v = 1'b0; end
      OP_XOR: begin r = a ^ b; v = 1'b0; end
      OP_COM: begin r = ~a; v = 1'b0; c = 1'b1; end
      OP_SWP: begin r = {a[HB:0], a[M:HB+1]}; upd = 1'b0; end
      OP_LSR, OP_ROR, OP_ASR: begin
        r[M-1:0] = a[M:1];
        r[M]     = (op == OP_ROR) ? cin : (op == OP_ASR) ? a[M] : 1'b0;
        c        = a[0];
        v        = r[M] ^ a[0];
      end
      default: begin upd = 1'b0; we = 1'b0; end
    endcase
    if (upd) begin
      n = r[M];
      z = (r == '0) & (~chain | flags_in[1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      write_en  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      write_en  <= in_valid & we;
      if (in_valid) begin
        result    <= r;
        flags_out <= upd ? {h, n ^ v, v, n, z, c} : flags_in;
      end
    end
  end
endmodule

module byte_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [4:0]   op,
  input logic [W-1:0] a,
  input logic [5:0]   flags_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic [5:0]   flags_out,
  input logic         write_en
);
  localparam int HB = W / 2 - 1;

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !write_en));
  p_incdec_keep_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 5'd6 || op == 5'd7)) |=> (flags_out[0] == $past(flags_in[0])));
  p_chain_no_set_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 5'd3 || op == 5'd5) && !flags_in[1]) |=> !flags_out[1]);
  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 5'd4 || op == 5'd5)) |=> !write_en);
  p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd13) |=>
      (result == {$past(a[HB:0]), $past(a[W-1:HB+1])} && flags_out == $past(flags_in)));
  p_sign_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op <= 5'd16 && op != 5'd13) |=>
      (flags_out[4] == (flags_out[2] ^ flags_out[3])));
endmodule

bind byte_alu byte_alu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a),
  .flags_in(flags_in), .out_valid(out_valid), .result(result),
  .flags_out(flags_out), .write_en(write_en)
);

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic [5:0] flags_in = '0;
  logic       out_valid, write_en;
  logic [7:0] result;
  logic [5:0] flags_out;

  int checks = 0;
  int fails  = 0;
  logic [14:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  byte_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .flags_in(flags_in), .out_valid(out_valid), .result(result),
    .flags_out(flags_out), .write_en(write_en)
  );

  // returns {write_en, flags[5:0] = {H,S,V,N,Z,C}, result[7:0]}
  function automatic logic [14:0] model(input logic [4:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic [5:0] f);
    int xi = int'(x), yi = int'(y), cc = 0, s = 0;
    logic [7:0] r = x;
    logic c = f[0], z = f[1], n = f[2], v = f[3], h = f[5];
    logic upd = 1'b1, chain = 1'b0, we = 1'b1;
    case (o)
      5'd0, 5'd1: begin
        cc = (o == 5'd1) ? int'(f[0]) : 0;
        s = xi + yi + cc;
        r = s[7:0];
        c = (s > 255);
        h = ((xi % 16) + (yi % 16) + cc) > 15;
        v = (x[7] == y[7]) && (r[7] != x[7]);
      end
      5'd2, 5'd3, 5'd4, 5'd5: begin
        cc = (o == 5'd3 || o == 5'd5) ? int'(f[0]) : 0;
        s = xi - yi - cc;
        r = s[7:0];
        c = (s < 0);
        h = (xi % 16) < ((yi % 16) + cc);
        v = (x[7] != y[7]) && (r[7] != x[7]);
        chain = (o == 5'd3 || o == 5'd5);
        we = !(o == 5'd4 || o == 5'd5);
      end
      5'd6: begin r = x + 8'd1; v = (x == 8'h7F); end
      5'd7: begin r = x - 8'd1; v = (x == 8'h80); end
      5'd8: begin r = x & y; v = 1'b0; end
      5'd9: begin r = x | y; v = 1'b0; end
      5'd10: begin r = x ^ y; v = 1'b0; end
      5'd11: begin r = ~x; v = 1'b0; c = 1'b1; end
      5'd12: begin
        s = 256 - xi;
        r = s[7:0];
        c = (x != 8'h00);
        h = (x[3:0] != 4'h0);
        v = (x == 8'h80);
      end
      5'd13: begin r = {x[3:0], x[7:4]}; upd = 1'b0; end
      5'd14: begin r = x >> 1; c = x[0]; v = c; end
      5'd15: begin r = {f[0], x[7:1]}; c = x[0]; v = r[7] ^ c; end
      5'd16: begin r = {x[7], x[7:1]}; c = x[0]; v = r[7] ^ c; end
      default: begin upd = 1'b0; we = 1'b0; end
    endcase
    if (upd) begin
      n = r[7];
      z = chain ? (f[1] && r == 8'h00) : (r == 8'h00);
      return {we, h, n ^ v, v, n, z, c, r};
    end
    return {we, f, r};
  endfunction

  task automatic send(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                      input logic [5:0] f, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y; flags_in = f;
    exp_q.push_back(model(o, x, y, f));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input logic ok, input string tag, input logic [14:0] act,
                       input logic [14:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", {write_en, flags_out, result}, 15'h0);
      end else begin
        logic [14:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({write_en, flags_out, result} == e, t, {write_en, flags_out, result}, e);
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "watchdog expired", 15'h0, 15'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({out_valid, write_en, flags_out, result} == 16'h0, "R1 reset state",
          {write_en, flags_out, result}, 15'h0);
    rst_n = 1'b1;
    idle(2);
    // R2 arithmetic
    send(5'd0, 8'h3A, 8'h47, 6'h00, "R2 add overflow/half-carry");
    send(5'd0, 8'hF0, 8'h10, 6'h00, "R2 add carry out zero");
    send(5'd1, 8'h7F, 8'h00, 6'h01, "R2 adc with carry");
    send(5'd2, 8'h10, 8'h21, 6'h00, "R2 sub borrow");
    send(5'd2, 8'h80, 8'h01, 6'h00, "R2 sub signed overflow");
    send(5'd2, 8'h55, 8'h55, 6'h00, "R2 sub equal zero");
    // R5 compares
    send(5'd4, 8'h20, 8'h30, 6'h00, "R5 cmp no write");
    send(5'd5, 8'h20, 8'h20, 6'h03, "R5 cpc no write");
    // R3 inc/dec
    send(5'd6, 8'hFF, 8'h00, 6'h21, "R3 inc wraps keeps C,H");
    send(5'd6, 8'h7F, 8'h00, 6'h00, "R3 inc overflow");
    send(5'd7, 8'h80, 8'h00, 6'h00, "R3 dec overflow keeps C");
    send(5'd7, 8'h00, 8'h00, 6'h01, "R3 dec wraps keeps C");
    // R4 chained Z
    send(5'd3, 8'h05, 8'h05, 6'h00, "R4 sbc zero with Z clear");
    send(5'd3, 8'h05, 8'h04, 6'h03, "R4 sbc zero with Z set and borrow");
    send(5'd5, 8'h09, 8'h03, 6'h02, "R4 cpc nonzero clears Z");
    send(5'd5, 8'h00, 8'h00, 6'h01, "R4 cpc borrow through zero");
    // R6 self add
    send(5'd0, 8'h96, 8'h96, 6'h00, "R6 add self shift left");
    send(5'd1, 8'h96, 8'h96, 6'h01, "R6 adc self rotate left");
    // R7 swap
    send(5'd13, 8'hA5, 8'h00, 6'h2A, "R7 swap keeps flags");
    // R8 shifts
    send(5'd14, 8'h81, 8'h00, 6'h20, "R8 lsr");
    send(5'd15, 8'h02, 8'h00, 6'h01, "R8 ror carry in");
    send(5'd16, 8'h81, 8'h00, 6'h00, "R8 asr keeps sign");
    send(5'd14, 8'h01, 8'h00, 6'h00, "R8 lsr to zero");
    // R9 logic
    send(5'd8, 8'hF0, 8'h3C, 6'h29, "R9 and keeps C,H clears V");
    send(5'd9, 8'h00, 8'h00, 6'h09, "R9 or zero");
    send(5'd10, 8'hFF, 8'h7F, 6'h00, "R9 xor");
    send(5'd11, 8'h0F, 8'h00, 6'h28, "R9 complement sets C");
    // R10 negate
    send(5'd12, 8'h00, 8'h00, 6'h00, "R10 neg zero");
    send(5'd12, 8'h80, 8'h00, 6'h00, "R10 neg 0x80");
    send(5'd12, 8'h01, 8'h00, 6'h00, "R10 neg one");
    send(5'd12, 8'h10, 8'h00, 6'h00, "R10 neg low nibble zero");
    // R11 unused codes
    send(5'd20, 8'h3C, 8'h11, 6'h15, "R11 unused code");
    send(5'd31, 8'hC3, 8'h22, 6'h2A, "R11 unused code top");
    idle(3);
    check(!out_valid && !write_en, "R1 idle after burst", {write_en, 14'h0}, 15'h0);
    check(exp_q.size() == 0, "R1 all outcomes delivered", 15'(exp_q.size()), 15'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule